// File: doc/BRIEF.md
# Parallel Move Legality Checker

This combinational unit sits in the decode stage of a DSP core. It looks at an instruction that pairs one arithmetic or logic operation with two register moves that run at the same time. It works out which register-file slots the two move paths would write. It also decides whether the pairing is allowed. A destination that overlaps the accumulator written by the ALU operation makes the instruction illegal. So does an addressing mode that the move class cannot encode. An illegal instruction writes no register.

The two move classes work as follows.

- **Class I:** path 1 moves a word between X memory (or an immediate) and a register. Path 2 copies an accumulator into a data ALU input register. Every addressing mode is allowed.
- **Class II:** path 1 stores an accumulator to X memory, so it writes no register. Path 2 copies input register X0 into an accumulator. Long absolute and long immediate modes are not allowed.

Sources are never checked. A register the ALU reads, or a register named by both move sources, raises nothing.

Register codes are 4 bits. Bits [3:1] hold a class field:

| Field value | Meaning |
|---|---|
| 0 | whole accumulator |
| 1 | low portion |
| 2 | middle portion |
| 3 | extension portion |
| 4 | input register 0 |
| 5 | input register 1 |
| 6, 7 | reserved |

Bit 0 selects the side: 0 means A or X, 1 means B or Y.

Write-enable vectors are 10 bits wide, one bit per slot:

| Bit | Slot |
|---|---|
| 0, 1, 2 | A0, A1, A2 |
| 3, 4, 5 | B0, B1, B2 |
| 6 | X0 |
| 7 | X1 |
| 8 | Y0 |
| 9 | Y1 |

Top module: `pm_move_legality`

## Requirements
- R1: In Class I (move_class=0) with p1_to_reg=1, p1_we holds the slots of p1_reg. A whole accumulator sets all three of its portion bits (A gives 0x007, B gives 0x038). A portion code sets its single bit.
- R2: In Class I with p1_to_reg=0 (register to memory), p1_we is zero. The register named by p1_reg is then only a source.
- R3: p2_we holds the slots of p2_dst. An input register code sets bit 6 + 2*side + (field==5).
- R4: In Class II (move_class=1), p1_we is zero whatever p1_to_reg is. p2_we holds the slots of the accumulator code in p2_dst.
- R5: When alu_wr_acc=1 and either active move destination (path 1 only when it writes a register) is any portion of the accumulator chosen by alu_acc_sel (0=A, 1=B), illegal=1 and reason=2'b01.
- R6: A move destination in the other accumulator is legal. So is an input register destination. So is a move source equal to the ALU destination accumulator.
- R7: In Class II, ea_mode 6 (long absolute) or 7 (long immediate) gives illegal=1 and reason=2'b10.
- R8: In Class I, every ea_mode value 0 to 7 is legal.
- R9: When both faults are present, reason is 2'b01.
- R10: Whenever illegal=1, p1_we and p2_we are both zero.
- R11: Register codes with field 6 or 7 set no write-enable bit and never cause an overlap.
- R12: With alu_wr_acc=0, no destination is flagged as an overlap.
- R13: When legal, reason is 2'b00 and illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_wr_acc | input | 1 | ALU operation writes an accumulator |
| alu_acc_sel | input | 1 | ALU destination accumulator, 0=A 1=B |
| move_class | input | 1 | 0 = Class I, 1 = Class II |
| p1_reg | input | 4 | Path 1 register code |
| p1_to_reg | input | 1 | Class I path 1 direction, 1 = into register |
| p2_dst | input | 4 | Path 2 destination register code |
| ea_mode | input | 3 | Addressing mode; 6 long absolute, 7 long immediate |
| illegal | output | 1 | Instruction rejected |
| reason | output | 2 | 00 legal, 01 duplicate destination, 10 mode not allowed |
| p1_we | output | 10 | Path 1 slot write enables |
| p2_we | output | 10 | Path 2 slot write enables |

## Verification
The bench targets several corner cases, each tied to a plausible defect:

- **Portion codes against the ALU accumulator.** A checker that compared full codes rather than accumulator identity would let A1 slip past an ALU write to A.
- **A Class I store of the ALU destination accumulator.** This is a source only, and a unit that flagged every overlap regardless of direction would wrongly reject it.
- **Class II long modes, alone and combined with an overlap.** A swapped priority would report the mode fault.
- **Reserved codes and Class II path 1.** These must write nothing; a loose decode would enable stray slots.

Random pairings fill in the rest of the space.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int PM_CLS_W  = 3;
   localparam int PM_CODE_W = PM_CLS_W + 1;
   localparam int PM_NSLOT  = 10;

   typedef enum logic [1:0] {
      RSN_OK   = 2'b00,
      RSN_DUP  = 2'b01,
      RSN_MODE = 2'b10
   } pm_reason_e;

   localparam logic [PM_CLS_W-1:0] CLS_WHOLE = 3'd0;
   localparam logic [PM_CLS_W-1:0] CLS_EXT   = 3'd3;
   localparam logic [PM_CLS_W-1:0] CLS_IN0   = 3'd4;
endpackage

// File: rtl/pm_reg_decode.sv
module pm_reg_decode
   import pm_pkg::*;
#(
   parameter int CLS_W  = PM_CLS_W,
   parameter int NSLOT  = PM_NSLOT,
   localparam int CODE_W = CLS_W + 1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              en,
   output logic [NSLOT-1:0]  slot_we,
   output logic              is_acc,
   output logic              side
);
   logic [CLS_W-1:0] cls;

   assign cls    = code[CODE_W-1:1];
   assign side   = code[0];
   assign is_acc = (cls <= CLS_W'(CLS_EXT));

   if (CLS_W < 3) begin : g_chk_cls
      $error("pm_reg_decode: class field needs at least 3 bits");
   end
   if (NSLOT != 10) begin : g_chk_slot
      $error("pm_reg_decode: slot map is fixed at 10 entries");
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam bit ACC  = (s < 6);
      localparam int SIDE = ACC ? (s / 3) : ((s - 6) / 2);
      localparam int PART = ACC ? (s % 3) : ((s - 6) % 2);
      if (ACC) begin : g_acc
         assign slot_we[s] = en && (side == 1'(SIDE)) &&
                             ((cls == CLS_W'(CLS_WHOLE)) || (cls == CLS_W'(PART + 1)));
      end else begin : g_inp
         assign slot_we[s] = en && (side == 1'(SIDE)) &&
                             (cls == CLS_W'(CLS_IN0 + PART));
      end
   end

   always_comb begin
      a_r11_reserved_quiet: assert (!(cls > CLS_W'(CLS_IN0 + 1)) || slot_we == '0);
   end
endmodule

// File: rtl/pm_mode_check.sv
module pm_mode_check #(
   parameter int MODE_W        = 3,
   parameter int MODE_LONG_ABS = 6,
   parameter int MODE_LONG_IMM = 7
) (
   input  logic              move_class,
   input  logic [MODE_W-1:0] ea_mode,
   output logic              mode_bad
);
   if (MODE_LONG_ABS >= (1 << MODE_W) || MODE_LONG_IMM >= (1 << MODE_W)) begin : g_chk
      $error("pm_mode_check: long mode codes do not fit the mode field");
   end

   logic is_long;
   assign is_long  = (ea_mode == MODE_W'(MODE_LONG_ABS)) || (ea_mode == MODE_W'(MODE_LONG_IMM));
   assign mode_bad = move_class && is_long;

   always_comb begin
      a_r8_class1_any_mode: assert (move_class || !mode_bad);
   end
endmodule

// File: rtl/pm_overlap_check.sv
module pm_overlap_check (
   input  logic alu_wr_acc,
   input  logic alu_acc_sel,
   input  logic d1_en,
   input  logic d1_is_acc,
   input  logic d1_side,
   input  logic d2_is_acc,
   input  logic d2_side,
   output logic dup
);
   logic hit1, hit2;
   assign hit1 = d1_en && d1_is_acc && (d1_side == alu_acc_sel);
   assign hit2 = d2_is_acc && (d2_side == alu_acc_sel);
   assign dup  = alu_wr_acc && (hit1 || hit2);

   always_comb begin
      a_r12_no_alu_no_dup: assert (alu_wr_acc || !dup);
   end
endmodule

// File: rtl/pm_move_legality.sv
module pm_move_legality
   import pm_pkg::*;
#(
   parameter int CLS_W         = PM_CLS_W,
   parameter int MODE_W        = 3,
   parameter int MODE_LONG_ABS = 6,
   parameter int MODE_LONG_IMM = 7,
   localparam int CODE_W = CLS_W + 1,
   localparam int NSLOT  = PM_NSLOT
) (
   input  logic              alu_wr_acc,
   input  logic              alu_acc_sel,
   input  logic              move_class,
   input  logic [CODE_W-1:0] p1_reg,
   input  logic              p1_to_reg,
   input  logic [CODE_W-1:0] p2_dst,
   input  logic [MODE_W-1:0] ea_mode,
   output logic              illegal,
   output logic [1:0]        reason,
   output logic [NSLOT-1:0]  p1_we,
   output logic [NSLOT-1:0]  p2_we
);
   logic             p1_en;
   logic [NSLOT-1:0] raw1, raw2;
   logic             acc1, side1, acc2, side2;
   logic             dup, mode_bad;

   assign p1_en = !move_class && p1_to_reg;

   pm_reg_decode #(.CLS_W(CLS_W), .NSLOT(NSLOT)) u_dec1 (
      .code(p1_reg), .en(p1_en), .slot_we(raw1), .is_acc(acc1), .side(side1));

   pm_reg_decode #(.CLS_W(CLS_W), .NSLOT(NSLOT)) u_dec2 (
      .code(p2_dst), .en(1'b1), .slot_we(raw2), .is_acc(acc2), .side(side2));

   pm_overlap_check u_ovl (
      .alu_wr_acc(alu_wr_acc), .alu_acc_sel(alu_acc_sel),
      .d1_en(p1_en), .d1_is_acc(acc1), .d1_side(side1),
      .d2_is_acc(acc2), .d2_side(side2), .dup(dup));

   pm_mode_check #(.MODE_W(MODE_W), .MODE_LONG_ABS(MODE_LONG_ABS),
                   .MODE_LONG_IMM(MODE_LONG_IMM)) u_mode (
      .move_class(move_class), .ea_mode(ea_mode), .mode_bad(mode_bad));

   always_comb begin
      if (dup)           reason = RSN_DUP;
      else if (mode_bad) reason = RSN_MODE;
      else               reason = RSN_OK;
   end

   assign illegal = dup || mode_bad;
   assign p1_we   = illegal ? '0 : raw1;
   assign p2_we   = illegal ? '0 : raw2;

   always_comb begin
      a_r10_we_low_when_illegal: assert (!illegal || (p1_we == '0 && p2_we == '0));
      a_r9_dup_priority: assert (!(dup && mode_bad) || reason == RSN_DUP);
      a_r4_class2_path1_quiet: assert (!move_class || p1_we == '0);
      a_r13_reason_tracks_flag: assert (illegal == (reason != RSN_OK));
   end
endmodule

// File: tb/pm_move_legality_bench.sv
module pm_move_legality_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       alu_wr_acc, alu_acc_sel, move_class, p1_to_reg;
   logic [3:0] p1_reg, p2_dst;
   logic [2:0] ea_mode;
   logic       illegal;
   logic [1:0] reason;
   logic [9:0] p1_we, p2_we;
   int         n_cmp = 0;
   int         n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pm_move_legality u_pm_move_legality (
      .alu_wr_acc(alu_wr_acc), .alu_acc_sel(alu_acc_sel), .move_class(move_class),
      .p1_reg(p1_reg), .p1_to_reg(p1_to_reg), .p2_dst(p2_dst), .ea_mode(ea_mode),
      .illegal(illegal), .reason(reason), .p1_we(p1_we), .p2_we(p2_we));

   function automatic int slots(int code);
      int f = code >> 1;
      int s = code & 1;
      if (f == 0) return (s != 0) ? 'h38 : 'h07;
      if (f <= 3) return 1 << (s * 3 + f - 1);
      if (f <= 5) return 1 << (6 + s * 2 + f - 4);
      return 0;
   endfunction

   function automatic bit in_acc(int code, int which);
      return ((code >> 1) <= 3) && ((code & 1) == which);
   endfunction

   function automatic int rc(int f, int s);
      return f * 2 + s;
   endfunction

   task automatic apply(string tag, bit aw, bit asel, bit cl, int r1, bit tr,
                        int d2, int md);
      bit d1act, dupx, modex, illx;
      int rx, w1x, w2x;
      @(posedge clk);
      #1;
      alu_wr_acc = aw; alu_acc_sel = asel; move_class = cl;
      p1_reg = 4'(r1); p1_to_reg = tr; p2_dst = 4'(d2); ea_mode = 3'(md);
      d1act = !cl && tr;
      dupx  = aw && ((d1act && in_acc(r1, asel)) || in_acc(d2, asel));
      modex = cl && (md == 6 || md == 7);
      illx  = dupx || modex;
      rx    = dupx ? 1 : (modex ? 2 : 0);
      w1x   = (illx || !d1act) ? 0 : slots(r1);
      w2x   = illx ? 0 : slots(d2);
      @(negedge clk);
      n_cmp++;
      if (illegal !== illx || reason !== 2'(rx) || p1_we !== 10'(w1x) || p2_we !== 10'(w2x)) begin
         n_bad++;
         $display("FAIL %s: got ill=%0b rsn=%0d we1=%h we2=%h exp ill=%0b rsn=%0d we1=%h we2=%h",
                  tag, illegal, reason, p1_we, p2_we, illx, rx, w1x, w2x);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      alu_wr_acc = 0; alu_acc_sel = 0; move_class = 0; p1_reg = 0;
      p1_to_reg = 0; p2_dst = 0; ea_mode = 0;
      apply("R13 idle legal", 0, 0, 0, rc(4, 0), 0, rc(4, 0), 0);
      apply("R1 whole B", 0, 0, 0, rc(0, 1), 1, rc(4, 0), 0);
      apply("R1 portion A1", 0, 0, 0, rc(2, 0), 1, rc(5, 1), 1);
      apply("R2 store to mem", 0, 0, 0, rc(0, 0), 0, rc(4, 1), 2);
      apply("R3 Y1 dest", 0, 0, 0, rc(4, 0), 1, rc(5, 1), 3);
      apply("R4 class2 acc dest", 0, 0, 1, rc(0, 0), 1, rc(0, 1), 4);
      apply("R5 A dest A1", 1, 0, 0, rc(2, 0), 1, rc(4, 0), 0);
      apply("R5 B dest via p2", 1, 1, 1, rc(0, 0), 0, rc(3, 1), 0);
      apply("R6 other acc", 1, 0, 0, rc(1, 1), 1, rc(4, 1), 0);
      apply("R6 shared source", 1, 0, 0, rc(0, 0), 0, rc(4, 0), 5);
      apply("R7 long abs", 0, 0, 1, rc(0, 0), 0, rc(0, 0), 6);
      apply("R7 long imm", 1, 1, 1, rc(0, 1), 0, rc(0, 0), 7);
      for (int m = 0; m < 8; m++) apply("R8 class1 mode", 0, 1, 0, rc(1, 0), 1, rc(4, 1), m);
      apply("R9 both faults", 1, 0, 1, rc(0, 0), 0, rc(2, 0), 7);
      apply("R10 we zero", 1, 1, 0, rc(0, 1), 1, rc(4, 0), 0);
      apply("R11 reserved p1", 1, 0, 0, rc(6, 0), 1, rc(7, 1), 0);
      apply("R12 no alu write", 0, 0, 0, rc(0, 0), 1, rc(0, 0), 0);
      for (int i = 0; i < 400; i++)
         apply("random", 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 16),
               1'($urandom), int'($urandom % 16), int'($urandom % 8));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule